// File: doc/BRIEF.md
# Reset Pulse Stretcher with Cause Logic

This block drives the active-low reset line that goes to a host microcontroller. Five event inputs can pull the line low: supply under-voltage on the logic regulator, a failed watchdog, second-level thermal shutdown, a wake-up that calls for a reset, and a forced sleep entry. The line stays low while any event is present. It then stays low for a fixed number of clock cycles after the last cycle in which an event was sampled, so the count always starts from the end of the event. Any event that arrives during that interval starts the count again.

The block stores the highest-priority cause seen during the current pulse. It uses that cause to decide how the rest of the chip behaves. Both bus transmitters are blocked for the whole pulse. The bus receivers stay enabled only if the cause is under-voltage. After a pulse caused by under-voltage or watchdog failure, the power-output enable stays off until a correct watchdog service is reported. The LIN transmitter is not re-enabled at release. It comes back only after the transmit-data input shows a fresh high-to-low edge. A single-cycle strobe marks the first released cycle so that surrounding logic can restart.

The stretch length is the parameter `STRETCH_CYC`, counted in clock cycles. The timer uses one counter, and the gating uses three flags.

Top module: `rst_stretch_ctl`

## Requirements
- R1: When any of the five event inputs is sampled high on a clock edge, `rst_out_n` is low in the following cycle.
- R2: `rst_out_n` stays low for exactly `STRETCH_CYC` cycles after the last edge at which an event was sampled high. A one-cycle event therefore gives exactly `STRETCH_CYC` low cycles.
- R3: An event sampled while the stretch is running reloads the count, so the `STRETCH_CYC` low cycles are counted again from that new event.
- R4: While `rst_out_n` is low, `can_tx_en_o` and `lin_tx_en_o` are both low.
- R5: While `rst_out_n` is low, `rx_en_o` is high only if the stored cause is under-voltage (code 5). In all other cases `rx_en_o` is low during the pulse. Whenever `rst_out_n` is high, `rx_en_o` is high.
- R6: Once an under-voltage or watchdog event has been sampled, `pwr_en_o` stays low until `wdg_good_i` is sampled high while `rst_out_n` is high. A `wdg_good_i` seen during the pulse has no effect. After a pulse caused only by thermal, wake or sleep events, `pwr_en_o` returns high as soon as the pulse ends, provided no hold is pending.
- R7: After a pulse, `lin_tx_en_o` stays low until a high-to-low change of `lin_txd_i` is sampled while `rst_out_n` is high. It goes high in the cycle after that edge.
- R8: `cause_o` holds the highest-priority source sampled during the current pulse, and keeps that value after release until the next pulse. The codes are: 0 none, 1 sleep, 2 wake, 3 thermal, 4 watchdog, 5 under-voltage. A higher code has higher priority.
- R9: `rel_pulse_o` is high for exactly one cycle: the first cycle in which `rst_out_n` is high again after a pulse.
- R10: After reset, `rst_out_n`, `can_tx_en_o`, `lin_tx_en_o` and `rx_en_o` are high. `cause_o` is 0, and `rel_pulse_o` and `pwr_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_vlow_i | input | 1 | Logic-regulator under-voltage (level) |
| ev_wdg_fail_i | input | 1 | Watchdog failure |
| ev_hot2_i | input | 1 | Second-level thermal shutdown |
| ev_wake_rst_i | input | 1 | Wake-up that requests a reset |
| ev_sleep_i | input | 1 | Forced sleep entry |
| wdg_good_i | input | 1 | Correct watchdog service strobe |
| lin_txd_i | input | 1 | LIN transmit data from host (high = recessive) |
| rst_out_n | output | 1 | Stretched reset to host, active low |
| rel_pulse_o | output | 1 | One-cycle strobe at reset release |
| cause_o | output | 3 | Stored reset cause code |
| lin_tx_en_o | output | 1 | LIN transmitter enable |
| can_tx_en_o | output | 1 | CAN transmitter enable |
| rx_en_o | output | 1 | CAN and LIN receiver enable |
| pwr_en_o | output | 1 | Power-output enable |

## Verification
A stretch counter that loads or decrements wrongly changes the pulse width. The bench counts every low cycle, so a single-cycle error shows up on the release edge of the first pulse. A stored cause that is wrong appears on `cause_o` in the first cycle of the pulse, and it also flips `rx_en_o` during the pulse. A hold flag or re-arm flag left in the wrong state shows at release as a `pwr_en_o` or `lin_tx_en_o` value that does not follow the watchdog service or the transmit edge. That mismatch is visible one cycle after the stimulus that should have changed it.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  localparam int unsigned SRC_N = 5;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_SLEEP = 3'd1,
    CAUSE_WAKE  = 3'd2,
    CAUSE_THERM = 3'd3,
    CAUSE_WDG   = 3'd4,
    CAUSE_UV    = 3'd5
  } cause_e;

endpackage

// File: rtl/rsc_cause_sel.sv
module rsc_cause_sel
  import rsc_pkg::*;
#(
  parameter int unsigned N_SRC = SRC_N
) (
  input  logic [N_SRC-1:0] src_i,    // bit i maps to code i+1
  input  logic             merge_i,  // pulse already running
  input  cause_e           held_i,
  output logic             any_o,
  output cause_e           next_o
);

  cause_e fresh;

  always_comb begin
    fresh = CAUSE_NONE;
    for (int i = 0; i < int'(N_SRC); i++) begin
      if (src_i[i]) fresh = cause_e'(3'(i + 1));
    end
  end

  assign any_o  = |src_i;
  assign next_o = (merge_i && (held_i > fresh)) ? held_i : fresh;

endmodule

// File: rtl/rsc_stretch_timer.sv
module rsc_stretch_timer #(
  parameter int unsigned STRETCH_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o,
  output logic last_o
);

  localparam int unsigned CW = $clog2(STRETCH_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(STRETCH_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == CW'(1));
  assign cnt_en = load_i | busy_o;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = LOAD_VAL;
    else if (busy_o) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3
  reload_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == LOAD_VAL));

  // R2
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD_VAL);

endmodule

// File: rtl/rsc_lin_rearm.sv
module rsc_lin_rearm (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_i,
  input  logic open_i,   // reset released
  input  logic block_i,  // pulse running or starting
  output logic armed_o
);

  logic prev_q, armed_q, armed_d, fall;

  assign fall    = prev_q & ~txd_i;
  assign armed_o = armed_q;

  always_comb begin
    armed_d = armed_q;
    if (block_i)             armed_d = 1'b0;
    else if (open_i && fall) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      armed_q <= 1'b1;
    end else begin
      prev_q  <= txd_i;
      armed_q <= armed_d;
    end
  end

  // R7
  rearm_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_o) |-> ($past(prev_q) && !$past(txd_i) && $past(open_i)));

  // R4
  block_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_i |=> !armed_o);

endmodule

// File: rtl/rst_stretch_ctl.sv
module rst_stretch_ctl
  import rsc_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_vlow_i,
  input  logic       ev_wdg_fail_i,
  input  logic       ev_hot2_i,
  input  logic       ev_wake_rst_i,
  input  logic       ev_sleep_i,
  input  logic       wdg_good_i,
  input  logic       lin_txd_i,
  output logic       rst_out_n,
  output logic       rel_pulse_o,
  output logic [2:0] cause_o,
  output logic       lin_tx_en_o,
  output logic       can_tx_en_o,
  output logic       rx_en_o,
  output logic       pwr_en_o
);

  logic [SRC_N-1:0] src;
  logic   any_ev, busy, last, armed;
  cause_e cause_q, cause_d;
  logic   hold_q, hold_d, hold_en;
  logic   rel_q, rel_d;
  logic   hold_trig;

  assign src = {ev_vlow_i, ev_wdg_fail_i, ev_hot2_i, ev_wake_rst_i, ev_sleep_i};

  rsc_cause_sel #(.N_SRC(SRC_N)) u_sel (
    .src_i  (src),
    .merge_i(busy),
    .held_i (cause_q),
    .any_o  (any_ev),
    .next_o (cause_d)
  );

  rsc_stretch_timer #(.STRETCH_CYC(STRETCH_CYC)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(any_ev),
    .busy_o(busy),
    .last_o(last)
  );

  rsc_lin_rearm u_rearm (
    .clk    (clk),
    .rst_n  (rst_n),
    .txd_i  (lin_txd_i),
    .open_i (!busy),
    .block_i(any_ev | busy),
    .armed_o(armed)
  );

  // next state
  assign hold_trig = any_ev & (ev_vlow_i | ev_wdg_fail_i);
  assign hold_en   = hold_trig | (wdg_good_i & !busy & !any_ev);
  assign hold_d    = hold_trig;
  assign rel_d     = last & !any_ev;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cause_q <= CAUSE_NONE;
    else if (any_ev) cause_q <= cause_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= 1'b1;
    else if (hold_en) hold_q <= hold_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= 1'b0;
    else        rel_q <= rel_d;
  end

  // outputs
  assign rst_out_n   = !busy;
  assign rel_pulse_o = rel_q;
  assign cause_o     = cause_q;
  assign can_tx_en_o = !busy;
  assign lin_tx_en_o = !busy & armed;
  assign rx_en_o     = !busy | (cause_q == CAUSE_UV);
  assign pwr_en_o    = !busy & !hold_q;

  // R1
  event_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_ev |=> !rst_out_n);

  // R8
  uv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ev && ev_vlow_i) |=> (cause_o == 3'd5));

  // R6
  hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_trig |=> !pwr_en_o);

  // R6
  pwr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwr_en_o) && $past(rst_out_n)) |-> $past(wdg_good_i));

  // R9
  rel_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse_o |-> (rst_out_n && $past(!rst_out_n)));

endmodule

// File: tb/sim_rst_stretch_ctl.sv
module sim_rst_stretch_ctl;

  localparam int S = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic ev_vlow, ev_wdg, ev_hot2, ev_wake, ev_sleep, wdg_good, lin_txd;
  logic rst_out_n, rel_pulse, lin_tx_en, can_tx_en, rx_en, pwr_en;
  logic [2:0] cause;

  always #2 clk = ~clk;

  rst_stretch_ctl #(.STRETCH_CYC(S)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_vlow_i(ev_vlow), .ev_wdg_fail_i(ev_wdg), .ev_hot2_i(ev_hot2),
    .ev_wake_rst_i(ev_wake), .ev_sleep_i(ev_sleep),
    .wdg_good_i(wdg_good), .lin_txd_i(lin_txd),
    .rst_out_n(rst_out_n), .rel_pulse_o(rel_pulse), .cause_o(cause),
    .lin_tx_en_o(lin_tx_en), .can_tx_en_o(can_tx_en),
    .rx_en_o(rx_en), .pwr_en_o(pwr_en)
  );

  typedef struct {
    string req;
    int    fld;
    int    exp;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    total = 0;
  int    fails = 0;
  bit    done  = 0;
  string fname[7] = '{"rst_out_n", "rel_pulse_o", "cause_o", "lin_tx_en_o",
                      "can_tx_en_o", "rx_en_o", "pwr_en_o"};

  function automatic int actual(int f);
    case (f)
      0: return int'(rst_out_n);
      1: return int'(rel_pulse);
      2: return int'(cause);
      3: return int'(lin_tx_en);
      4: return int'(can_tx_en);
      5: return int'(rx_en);
      default: return int'(pwr_en);
    endcase
  endfunction

  // monitor: pops expected items and compares them with the ports
  always @(chk_ev) begin
    while (q.size() > 0) begin
      item_t it;
      int a;
      it = q.pop_front();
      a  = actual(it.fld);
      total++;
      if (a != it.exp) begin
        fails++;
        $display("FAIL %s %s actual=%0d expected=%0d", it.req, fname[it.fld], a, it.exp);
      end
    end
  end

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(string r, int f, int e);
    item_t it;
    it.req = r;
    it.fld = f;
    it.exp = e;
    q.push_back(it);
  endtask

  task automatic go;
    ->chk_ev;
    #1;
  endtask

  task automatic release_run(string r, int n_low);
    for (int i = 0; i < n_low; i++) begin
      tick;
      chk(r, 0, 0);
      go;
    end
    tick;
    chk(r, 0, 1);
    chk("R9", 1, 1);
    chk("R4", 4, 1);
    go;
    tick;
    chk("R9", 1, 0);
    go;
  endtask

  task automatic service;
    wdg_good = 1'b1;
    tick;
    wdg_good = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ev_vlow = 0; ev_wdg = 0; ev_hot2 = 0; ev_wake = 0; ev_sleep = 0;
    wdg_good = 0; lin_txd = 1'b1;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    // R10 reset state
    chk("R10", 0, 1); chk("R10", 1, 0); chk("R10", 2, 0); chk("R10", 3, 1);
    chk("R10", 4, 1); chk("R10", 5, 1); chk("R10", 6, 0);
    go;

    service;
    chk("R6", 6, 1);
    go;

    // single-cycle watchdog failure
    ev_wdg = 1'b1;
    tick;
    ev_wdg = 1'b0;
    chk("R1", 0, 0); chk("R8", 2, 4); chk("R4", 3, 0); chk("R4", 4, 0);
    chk("R5", 5, 0); chk("R6", 6, 0);
    go;
    release_run("R2", S - 1);
    chk("R7", 3, 0); chk("R5", 5, 1); chk("R6", 6, 0);
    go;
    tick; tick;
    chk("R7", 3, 0);
    go;

    // LIN re-arm by falling edge
    lin_txd = 1'b0;
    tick;
    chk("R7", 3, 1);
    go;
    lin_txd = 1'b1;
    tick;
    chk("R7", 3, 1);
    go;
    service;
    chk("R6", 6, 1);
    go;

    // level under-voltage, watchdog service during the pulse is ignored
    ev_vlow = 1'b1;
    tick;
    chk("R1", 0, 0); chk("R8", 2, 5); chk("R5", 5, 1); chk("R4", 4, 0); chk("R4", 3, 0);
    go;
    repeat (15) tick;
    chk("R2", 0, 0); chk("R5", 5, 1);
    go;
    ev_vlow = 1'b0;
    wdg_good = 1'b1;
    tick;
    wdg_good = 1'b0;
    chk("R2", 0, 0);
    go;
    release_run("R2", S - 2);
    chk("R6", 6, 0); chk("R5", 5, 1); chk("R7", 3, 0); chk("R8", 2, 5);
    go;

    // restart of stretch; higher cause kept
    ev_wdg = 1'b1;
    tick;
    ev_wdg = 1'b0;
    chk("R3", 0, 0);
    go;
    repeat (4) tick;
    ev_hot2 = 1'b1;
    tick;
    ev_hot2 = 1'b0;
    chk("R8", 2, 4); chk("R5", 5, 0);
    go;
    release_run("R3", S - 1);

    // thermal alone: no hold after release
    service;
    chk("R6", 6, 1);
    go;
    ev_hot2 = 1'b1;
    tick;
    ev_hot2 = 1'b0;
    chk("R8", 2, 3); chk("R6", 6, 0); chk("R5", 5, 0);
    go;
    release_run("R2", S - 1);
    chk("R6", 6, 1);
    go;

    // wake and sleep together
    ev_wake = 1'b1;
    ev_sleep = 1'b1;
    tick;
    ev_wake = 1'b0;
    ev_sleep = 1'b0;
    chk("R8", 2, 2); chk("R5", 5, 0);
    go;
    release_run("R2", S - 1);
    chk("R8", 2, 2);
    go;

    // sleep alone
    ev_sleep = 1'b1;
    tick;
    ev_sleep = 1'b0;
    chk("R8", 2, 1);
    go;
    release_run("R2", S - 1);
    chk("R6", 6, 1);
    go;

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule